// File: doc/BRIEF.md
# Fibonacci Link Codeword Checker and Decoder

This block sits on the receive side of a router link that carries crosstalk-avoiding codewords. Each codeword has 48 bits. The low 46 bits hold a number in a Fibonacci-weighted form. Bit 46 repeats bit 45, so the tail keeps the pattern rules. Bit 47 makes the parity of the whole word even.

On every accepted codeword the block does three things:
- It recomputes the parity and raises an error flag when the parity does not agree. The router can then ask for the word to be sent again.
- It rebuilds the 32-bit data word as a weighted sum of the Fibonacci field.
- It hands the received codeword out unchanged. A router in the middle of a path can then check the word and pass it on without encoding it again.

All results leave through one register stage and are qualified by a single output valid bit.

Top module: `fib_link_decoder`

## Requirements
- R1: While reset is asserted and after it is released, out_valid, out_err, out_data and out_cw are all zero until the first accepted codeword.
- R2: For an accepted codeword, out_err is 1 exactly when the XOR of all 48 received bits is 1. In other terms, the parity recomputed over bits 0 to 46 differs from bit 47.
- R3: When out_err is 0, out_data equals the sum over i = 0..45 of bit i times F(i+2), truncated to 32 bits. F(0)=0, F(1)=1 and F(n)=F(n-1)+F(n-2), so bit 0 weighs 1, bit 1 weighs 2, bit 2 weighs 3, and so on.
- R4: When out_err is 1, out_data is zero.
- R5: out_cw equals the accepted codeword bit for bit, whether or not an error is flagged.
- R6: out_valid is high in exactly the cycle after each cycle in which in_valid is high. Back-to-back codewords produce back-to-back results.
- R7: In a cycle after in_valid is low, out_valid is low and out_data, out_cw and out_err keep their previous values.
- R8: A codeword built by the encoding rule with any single bit inverted, at any of the 48 positions, gives out_err = 1.
- R9: The extreme data words decode correctly: 0 (all-zero codeword) and 0xFFFFFFFF. The latter needs the weight of bit 45, F(47), which is above 2^31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Codeword on in_cw is accepted this cycle |
| in_cw | input | 48 | Received link codeword |
| out_valid | output | 1 | Result registers hold a new result |
| out_err | output | 1 | Parity check failed for the result |
| out_data | output | 32 | Decoded data word |
| out_cw | output | 48 | Received codeword, forwarded unchanged |

## Verification
The bench builds the block with its default widths: a 46-bit Fibonacci field and 32-bit data, giving a 48-bit codeword. This puts the top weight F(47) and the full 32-bit range within reach, including the truncation of the 33-bit sum. Codewords come from a bench-side greedy encoder. With them the bench covers the edge values 0 and 0xFFFFFFFF, random words, and an inversion of every one of the 48 bit positions of several valid words. Gaps between codewords let it observe the hold behaviour.

// File: rtl/fibdec_pkg.sv
package fibdec_pkg;

  // Fibonacci number F(n) with F(0)=0, F(1)=1.
  function automatic logic [63:0] fib_num(input int unsigned n);
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] t;
    a = 64'd0;
    b = 64'd1;
    for (int unsigned k = 0; k < n; k++) begin
      t = a + b;
      a = b;
      b = t;
    end
    return a;
  endfunction

  // Smallest power of two not below n.
  function automatic int unsigned pow2_ceil(input int unsigned n);
    int unsigned p;
    p = 1;
    while (p < n) p = p * 2;
    return p;
  endfunction

endpackage

// File: rtl/fib_parity_check.sv
module fib_parity_check #(
  parameter int unsigned CW_W = 48
) (
  input  logic [CW_W-1:0] cw,
  output logic            parity_bad
);
  // The tail pair keeps total parity even, so any odd count of flips shows.
  always_comb parity_bad = ^cw;
endmodule

// File: rtl/fib_weight_sum.sv
module fib_weight_sum #(
  parameter int unsigned FIB_W  = 46,
  parameter int unsigned DATA_W = 32
) (
  input  logic [FIB_W-1:0]  field,
  output logic [DATA_W-1:0] total
);
  import fibdec_pkg::*;

  localparam int unsigned LEAVES = pow2_ceil(FIB_W);
  localparam int unsigned NODES  = 2 * LEAVES - 1;

  // Heap-ordered tree: node 0 is the root, leaves start at LEAVES-1.
  logic [DATA_W-1:0] node [NODES];

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < FIB_W) begin : g_used
      localparam logic [DATA_W-1:0] WGT = DATA_W'(fib_num(i + 2));
      assign node[LEAVES-1+i] = field[i] ? WGT : '0;
    end else begin : g_pad
      assign node[LEAVES-1+i] = '0;
    end
  end

  for (genvar j = 0; j < LEAVES - 1; j++) begin : g_add
    assign node[j] = node[2*j+1] + node[2*j+2];
  end

  assign total = node[0];
endmodule

// File: rtl/fib_out_stage.sv
module fib_out_stage #(
  parameter int unsigned CW_W   = 48,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              err_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic [CW_W-1:0]   cw_in,
  output logic              valid_q,
  output logic              err_q,
  output logic [DATA_W-1:0] data_q,
  output logic [CW_W-1:0]   cw_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      data_q  <= '0;
      cw_q    <= '0;
    end else begin
      valid_q <= accept;
      if (accept) begin
        err_q  <= err_in;
        data_q <= err_in ? '0 : data_in;
        cw_q   <= cw_in;
      end
    end
  end
endmodule

// File: rtl/fib_link_decoder.sv
module fib_link_decoder #(
  parameter int unsigned FIB_W  = 46,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CW_W   = FIB_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CW_W-1:0]   in_cw,
  output logic              out_valid,
  output logic              out_err,
  output logic [DATA_W-1:0] out_data,
  output logic [CW_W-1:0]   out_cw
);
  // Named internal events, observed by the bound checker.
  logic              parity_bad;
  logic              accept;
  logic [DATA_W-1:0] sum_value;

  assign accept = in_valid;

  fib_parity_check #(.CW_W(CW_W)) u_par (
    .cw         (in_cw),
    .parity_bad (parity_bad)
  );

  fib_weight_sum #(.FIB_W(FIB_W), .DATA_W(DATA_W)) u_sum (
    .field (in_cw[FIB_W-1:0]),
    .total (sum_value)
  );

  fib_out_stage #(.CW_W(CW_W), .DATA_W(DATA_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .err_in  (parity_bad),
    .data_in (sum_value),
    .cw_in   (in_cw),
    .valid_q (out_valid),
    .err_q   (out_err),
    .data_q  (out_data),
    .cw_q    (out_cw)
  );
endmodule

// File: rtl/fib_link_decoder_chk.sv
module fib_link_decoder_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CW_W   = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [CW_W-1:0]   in_cw,
  input logic              out_valid,
  input logic              out_err,
  input logic [DATA_W-1:0] out_data,
  input logic [CW_W-1:0]   out_cw,
  input logic              parity_bad
);
  p_err_parity_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_err == ^$past(in_cw)));

  p_err_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_err == $past(parity_bad)));

  p_data_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_data == '0));

  p_fwd_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_cw == $past(in_cw)));

  p_valid_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_data) && $stable(out_cw) && $stable(out_err)));
endmodule

bind fib_link_decoder fib_link_decoder_chk #(.DATA_W(DATA_W), .CW_W(CW_W)) u_chk (.*);

// File: tb/fib_link_decoder_tb.sv
module fib_link_decoder_tb;
  localparam int FW = 46;
  localparam int DW = 32;
  localparam int CW = 48;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [CW-1:0] in_cw = '0;
  logic          out_valid;
  logic          out_err;
  logic [DW-1:0] out_data;
  logic [CW-1:0] out_cw;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #5 clk = ~clk;

  fib_link_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cw(in_cw),
    .out_valid(out_valid), .out_err(out_err), .out_data(out_data), .out_cw(out_cw)
  );

  // Fibonacci by table-free recursion on pairs, written independently.
  function automatic longint unsigned tb_fib(input int n);
    longint unsigned x = 0, y = 1;
    for (int k = 0; k < n; k++) begin
      y = x + y;
      x = y - x;
    end
    return x;
  endfunction

  // Greedy encoder: field bits, repeated top bit, even-parity bit.
  function automatic logic [CW-1:0] tb_encode(input logic [DW-1:0] d);
    logic [CW-1:0] c = '0;
    longint unsigned r = longint'(d);
    for (int i = FW - 1; i >= 0; i--) begin
      if (r >= tb_fib(i + 2)) begin
        c[i] = 1'b1;
        r    = r - tb_fib(i + 2);
      end
    end
    c[FW]   = c[FW-1];
    c[FW+1] = ^c[FW:0];
    return c;
  endfunction

  function automatic logic [DW-1:0] tb_value(input logic [CW-1:0] c);
    longint unsigned s = 0;
    for (int i = 0; i < FW; i++) if (c[i]) s = s + tb_fib(i + 2);
    return s[DW-1:0];
  endfunction

  task automatic check(input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Present one codeword for a cycle, then look at the registered result.
  task automatic send_and_check(input logic [CW-1:0] c, input string req);
    logic             e_err;
    logic [DW-1:0]    e_data;
    @(negedge clk);
    in_valid = 1'b1;
    in_cw    = c;
    @(negedge clk);
    in_valid = 1'b0;
    e_err  = ^c;
    e_data = e_err ? '0 : tb_value(c);
    check("R6", "out_valid", out_valid, 1);
    check(req, "out_err", out_err, e_err);
    check(e_err ? "R4" : "R3", "out_data", out_data, e_data);
    check("R5", "out_cw", out_cw, c);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] c;
    logic [DW-1:0] d;
    logic [DW-1:0] held_d;
    logic [CW-1:0] held_c;
    void'($urandom(32'h5eed_0042));

    repeat (3) @(negedge clk);
    check("R1", "out_valid in reset", out_valid, 0);
    check("R1", "out_data in reset", out_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "out_valid after reset", out_valid, 0);
    check("R1", "out_err after reset", out_err, 0);
    check("R1", "out_cw after reset", out_cw, 0);

    // R9 extremes
    send_and_check(tb_encode(32'h0), "R9");
    check("R9", "zero data", out_data, 0);
    send_and_check(tb_encode(32'hFFFF_FFFF), "R9");
    check("R9", "all-ones data", out_data, 32'hFFFF_FFFF);
    send_and_check(tb_encode(32'h8000_0000), "R3");

    // R7 hold after an idle cycle
    held_d = out_data;
    held_c = out_cw;
    @(negedge clk);
    check("R7", "out_valid idle", out_valid, 0);
    check("R7", "out_data held", out_data, held_d);
    check("R7", "out_cw held", out_cw, held_c);

    // Random words, decode (R3)
    for (int k = 0; k < 150; k++) begin
      d = $urandom();
      c = tb_encode(d);
      send_and_check(c, "R2");
      check("R3", "round trip", out_data, d);
    end

    // R8: every single-bit inversion of several valid words
    for (int w = 0; w < 4; w++) begin
      d = (w == 0) ? 32'hFFFF_FFFF : (w == 1) ? 32'h0 : $urandom();
      for (int b = 0; b < CW; b++) begin
        c = tb_encode(d);
        c[b] = ~c[b];
        send_and_check(c, "R8");
      end
    end

    // R6 back-to-back stream
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      d = $urandom();
      in_valid = 1'b1;
      in_cw = tb_encode(d);
      @(negedge clk);
      check("R6", "stream valid", out_valid, 1);
      check("R6", "stream data", out_data, d);
    end
    in_valid = 1'b0;
    @(negedge clk);
    check("R7", "valid drops", out_valid, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule